// File: doc/BRIEF.md
# Write-Busy Status Read Responder

This block sits on the read path of a byte-wide nonvolatile memory model. When the model's self-timed program cycle is idle, a read access returns the byte fetched from the storage array. While a program cycle is running, the block replaces that byte with a status word. The status word carries two separate completion indicators:

- The top bit is the inverse of the top bit of the byte most recently written.
- The second bit from the top changes value on every read access.

The low six bits of the status word are driven to zero so that results are repeatable.

The read strobe is registered first. Only its rising edge is treated as a read access, so one access causes one toggle step however long the strobe is held. Each access start makes a decision, and that decision is held on the output until the next access starts. A fall of the busy flag therefore shows up only on the next read, and no byte mixing status and array data is ever returned.

The block is built around a two-state machine:

- **ST_READY** presents captured array data.
- **ST_POLL** presents the status word.

Its transitions are:

- **T_ENTER_POLL**: ST_READY to ST_POLL, taken on an access start while busy.
- **T_STAY_POLL**: ST_POLL to ST_POLL, taken on an access start while still busy.
- **T_LEAVE_POLL**: ST_POLL to ST_READY, taken on an access start after busy has dropped.
- **T_STAY_READY**: ST_READY to ST_READY, taken on an access start while idle.

With no access start, the machine keeps its state.

Top module: `wbs_status_responder`

## Requirements
- R1: After reset, `rd_data` is 8'h00 and the toggle bit is 0, so the first read made while busy returns 1 on bit 6.
- R2: A read access that starts while `busy` is 1 returns on bit 7 the inverse of `last_wr_msb`, sampled at that access start.
- R3: A read access that starts while `busy` is 1 returns zero on bits 5 to 0.
- R4: Each read access that starts while `busy` is 1 inverts bit 6 relative to the previous busy read.
- R5: A read access that starts while `busy` is 0 returns all eight bits of `array_data`, sampled at that access start.
- R6: Read accesses made while `busy` is 0 do not advance the toggle, so the next busy read continues the alternation from its last value.
- R7: One access is one rising edge of `rd_strobe`. Holding the strobe high for many cycles produces exactly one toggle step.
- R8: The result of an access appears on `rd_data` two clock edges after `rd_strobe` rises. It then stays unchanged until the next access start, even if `busy`, `array_data` or `last_wr_msb` change in between.
- R9: After `busy` falls, the first read access starting later returns true array data with no status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Read access strobe, high for the duration of an access |
| busy | input | 1 | High while the program cycle runs |
| last_wr_msb | input | 1 | Top bit of the byte most recently written |
| array_data | input | 8 | Byte read from the storage array |
| rd_data | output | 8 | Byte to drive onto the data bus |

## Verification
The strobe passes one register before its rising edge is detected. The state, toggle and capture registers load on the following edge, so each result is due on the second rising clock edge after the strobe is first sampled high. The bench raises the strobe just after a falling edge and samples `rd_data` two falling edges later. For R8 it changes `busy`, `last_wr_msb` and `array_data` between accesses, waits several cycles and checks that the output has not moved. For R7 it holds the strobe high for many cycles and checks that the toggle bit advanced once.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_POLL  = 1'b1
    } wbs_state_t;

endpackage

// File: rtl/wbs_access_detect.sv
module wbs_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    output logic access_start
);

    logic strobe_q;
    logic strobe_qq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q  <= 1'b0;
            strobe_qq <= 1'b0;
        end else begin
            strobe_q  <= rd_strobe;
            strobe_qq <= strobe_q;
        end
    end

    assign access_start = strobe_q & ~strobe_qq;

    // R7: an access start never occurs on two consecutive cycles
    a_r7_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        access_start |=> !access_start);

endmodule

// File: rtl/wbs_toggle_cell.sv
module wbs_toggle_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic toggle_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
        end else if (advance) begin
            toggle_q <= ~toggle_q;
        end
    end

    // R6: without an advance the toggle holds its value
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(toggle_q));

    // R4: an advance always changes the toggle
    a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (toggle_q != $past(toggle_q)));

endmodule

// File: rtl/wbs_status_former.sv
module wbs_status_former #(
    parameter int  DATA_W = 8,
    parameter logic [DATA_W-3:0] FILL = '0
) (
    input  logic              poll_src,
    input  logic              toggle_bit,
    output logic [DATA_W-1:0] status_word
);

    localparam int POLL_POS = DATA_W - 1;
    localparam int TOG_POS  = DATA_W - 2;

    always_comb begin
        status_word             = '0;
        status_word[TOG_POS-1:0] = FILL;
        status_word[TOG_POS]    = toggle_bit;
        status_word[POLL_POS]   = ~poll_src;
    end

endmodule

// File: rtl/wbs_status_responder.sv
module wbs_status_responder
    import wbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              busy,
    input  logic              last_wr_msb,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int POLL_POS = DATA_W - 1;
    localparam int TOG_POS  = DATA_W - 2;

    wbs_state_t        state_q;
    wbs_state_t        state_d;
    logic              access_start;
    logic              poll_start;
    logic              toggle_q;
    logic              poll_src_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] status_word;

    wbs_access_detect u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_strobe    (rd_strobe),
        .access_start (access_start)
    );

    assign poll_start = access_start & busy;

    wbs_toggle_cell u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (poll_start),
        .toggle_q (toggle_q)
    );

    wbs_status_former #(
        .DATA_W (DATA_W)
    ) u_former (
        .poll_src    (poll_src_q),
        .toggle_bit  (toggle_q),
        .status_word (status_word)
    );

    // next state: T_ENTER_POLL, T_STAY_POLL, T_LEAVE_POLL, T_STAY_READY
    always_comb begin
        state_d = state_q;
        if (access_start) begin
            unique case (state_q)
                ST_READY: state_d = busy ? ST_POLL  : ST_READY;
                ST_POLL:  state_d = busy ? ST_POLL  : ST_READY;
                default:  state_d = ST_READY;
            endcase
        end
    end

    // state register and per-access capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_READY;
            poll_src_q <= 1'b0;
            data_q     <= '0;
        end else begin
            state_q <= state_d;
            if (access_start) begin
                if (busy) begin
                    poll_src_q <= last_wr_msb;
                end else begin
                    data_q <= array_data;
                end
            end
        end
    end

    // output selection by state
    always_comb begin
        unique case (state_q)
            ST_READY: rd_data = data_q;
            ST_POLL:  rd_data = status_word;
            default:  rd_data = data_q;
        endcase
    end

    // R2: busy read returns inverted write bit
    a_r2_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        poll_start |=> (rd_data[POLL_POS] == ~$past(last_wr_msb)));

    // R3: busy read returns zero fill on low bits
    a_r3_fill: assert property (@(posedge clk) disable iff (!rst_n)
        poll_start |=> (rd_data[TOG_POS-1:0] == '0));

    // R5, R9: idle read returns true data
    a_r5_true_data: assert property (@(posedge clk) disable iff (!rst_n)
        (access_start && !busy) |=> (rd_data == $past(array_data)));

    // R8: output moves only at access start
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !access_start |=> $stable(rd_data));

endmodule

// File: tb/tb_wbs_status_responder.sv
module tb_wbs_status_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       busy = 1'b0;
    logic       last_wr_msb = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wbs_status_responder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_strobe   (rd_strobe),
        .busy        (busy),
        .last_wr_msb (last_wr_msb),
        .array_data  (array_data),
        .rd_data     (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: strobe high for hold cycles, result sampled two falling edges after rise
    task automatic do_read(input int hold, output logic [7:0] val);
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        val = rd_data;
        for (int i = 2; i < hold; i++) @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset output", rd_data, 8'h00);
    endtask

    task automatic t_busy_reads();
        logic [7:0] v;
        busy = 1'b1;
        last_wr_msb = 1'b0;
        array_data = 8'h3C;
        do_read(2, v);
        check("R1 R2 R3 first busy read", v, 8'hC0);
        last_wr_msb = 1'b1;
        do_read(2, v);
        check("R2 R4 second busy read", v, 8'h00);
        do_read(3, v);
        check("R4 third busy read", v, 8'h40);
        last_wr_msb = 1'b0;
        do_read(2, v);
        check("R2 R3 R4 fourth busy read", v, 8'h80);
    endtask

    task automatic t_long_strobe();
        logic [7:0] v;
        do_read(12, v);
        check("R7 long access one step", v, 8'hC0);
        check("R7 long access after release", rd_data, 8'hC0);
        do_read(2, v);
        check("R7 next access", v, 8'h80);
    endtask

    task automatic t_drop_busy();
        logic [7:0] v;
        busy = 1'b0;
        array_data = 8'h5A;
        last_wr_msb = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 hold after busy drop", rd_data, 8'h80);
        do_read(2, v);
        check("R9 first read after drop", v, 8'h5A);
    endtask

    task automatic t_idle_reads();
        logic [7:0] v;
        array_data = 8'hFF;
        do_read(2, v);
        check("R5 idle all ones", v, 8'hFF);
        array_data = 8'hA5;
        do_read(4, v);
        check("R5 idle pattern", v, 8'hA5);
        array_data = 8'h11;
        busy = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 hold between accesses", rd_data, 8'hA5);
        last_wr_msb = 1'b1;
        do_read(2, v);
        check("R6 toggle resumes after idle", v, 8'h40);
        busy = 1'b0;
        array_data = 8'h00;
        do_read(2, v);
        check("R5 idle zeros", v, 8'h00);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy_reads();
        t_long_strobe();
        t_drop_busy();
        t_idle_reads();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule